// File: doc/BRIEF.md
# Register-Write Bytecode Sequencer

This block runs a short byte-coded script from a local program memory. The script issues 32-bit register writes on a write-only bus. It can also drive or release flag outputs, wait for a flag input to reach a value, and pause for a timed number of microseconds. A host fills the program memory one 32-bit word at a time and then pulses `start`. Execution always begins at byte 0. `busy` stays high until the script ends.

Program bytes are packed little-endian into words, so byte k of word w is bits `8k+7:8k`. The sequencer keeps an address register and a data register that hold their values between opcodes and between runs. Short forms of the load opcodes replace only the low half of a register and keep the upper half. Each address load issues one bus write, using the data register as it stands.

Top module: `regscript_engine`

## Requirements
- R1: After reset, `busy`, `wr_valid`, `flag_out` and `flag_drive` are 0. The held address and held data registers both start as all ones.
- R2: A `start` pulse while idle begins execution at byte 0, and `busy` is high from the next cycle. Each plain opcode byte takes one cycle. Byte 0x7F ends the run, and `busy` drops after the edge that processes it.
- R3: Opcode 0xE2 takes four following bytes, least significant first, and loads the full data register. Opcode 0x42 takes two bytes that replace data bits 15:0 and keep bits 31:16.
- R4: Opcode 0xE0 takes four following bytes, least significant first, and loads the full address register. Opcode 0x40 takes two bytes that replace address bits 15:0 and keep bits 31:16. Both registers keep their values from one run to the next.
- R5: After every address load (0xE0 or 0x40), `wr_valid` is high for exactly one cycle. In that cycle `wr_addr` is the new address and `wr_data` is the current data register. No other opcode writes to the bus.
- R6: Byte 0x80+n leaves flag n undriven (`flag_drive[n]`=0) and keeps its value. Byte 0xA0+n drives flag n to 0. Byte 0xC0+n drives flag n to 1. Here n is 0..31, and a value of n at or above NUM_FLAGS has no effect.
- R7: Opcode 0x5F is followed by an index byte and a value byte. Execution stalls, with no bus writes and no later opcodes, until `flag_in[index]` equals bit 0 of the value byte.
- R8: Any other byte with bit 7 clear encodes shift in bits 6:2 and count in bits 1:0. The four codes 0x40, 0x42, 0x5F and 0x7F are excluded. Such a byte stalls for count×4^shift microseconds, that is count×4^shift×CYC_PER_US clock cycles. A count of 0 does not stall. So the script [delay, 0x7F] holds `busy` for 2+count×4^shift×CYC_PER_US cycles.
- R9: When execution reaches byte address 4×DEPTH_WORDS without meeting 0x7F, the run ends. A memory full of 0x00 bytes keeps `busy` high for 4×DEPTH_WORDS+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program word write enable |
| prog_waddr | input | log2(DEPTH_WORDS) | Program word index |
| prog_wdata | input | 32 | Program word, bytes packed little-endian |
| start | input | 1 | Launches the script from byte 0; ignored while busy |
| busy | output | 1 | High while the script runs |
| wr_valid | output | 1 | One-cycle bus write strobe |
| wr_addr | output | 32 | Bus write address |
| wr_data | output | 32 | Bus write data |
| flag_in | input | NUM_FLAGS | Flags that wait opcodes test |
| flag_out | output | NUM_FLAGS | Flag output values |
| flag_drive | output | NUM_FLAGS | High where a flag output is actively driven |

## Verification
The hardest state to reach from the ports is the stall on a flag wait, because it must be held open long enough to show that no later opcode leaks through. The bench parks `flag_in` at the opposite value for tens of cycles and watches the write log and `busy`. It then flips the flag and expects the single pending write. Delay timing is swept over every count and the low shifts, and the measured `busy` length is compared against the arithmetic formula. The end-of-memory exit is reached by filling every word with zero-count delay bytes, which leaves no terminator in memory.

// File: rtl/regscript_pkg.sv
package regscript_pkg;

   localparam logic [7:0] OP_DATA_FULL = 8'hE2;
   localparam logic [7:0] OP_DATA_LOW  = 8'h42;
   localparam logic [7:0] OP_ADDR_FULL = 8'hE0;
   localparam logic [7:0] OP_ADDR_LOW  = 8'h40;
   localparam logic [7:0] OP_WAIT_FLAG = 8'h5F;
   localparam logic [7:0] OP_END       = 8'h7F;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPCODE,
      ST_ARGS,
      ST_WAIT,
      ST_DELAY
   } seq_state_t;

   typedef enum logic [1:0] {
      AK_DATA,
      AK_ADDR,
      AK_WAIT
   } arg_kind_t;

endpackage

// File: rtl/regscript_progmem.sv
module regscript_progmem #(
   parameter int DEPTH_WORDS = 64,
   localparam int WAW = $clog2(DEPTH_WORDS),
   localparam int BAW = WAW + 2
) (
   input  logic           clk,
   input  logic           wr_en,
   input  logic [WAW-1:0] wr_addr,
   input  logic [31:0]    wr_data,
   input  logic [BAW-1:0] rd_byte_addr,
   output logic [7:0]     rd_byte
);

   logic [31:0] mem [DEPTH_WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_byte = mem[rd_byte_addr[BAW-1:2]][{rd_byte_addr[1:0], 3'b000} +: 8];

endmodule

// File: rtl/regscript_delay.sv
module regscript_delay #(
   parameter int CYC_PER_US = 125,
   parameter int US_W       = 64,
   localparam int PRE_W     = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [US_W-1:0] load_us,
   output logic            active,
   output logic            done
);

   logic [US_W-1:0] rem;
   logic            act;
   logic            tick;

   if (CYC_PER_US == 1) begin : g_no_prescale
      assign tick = 1'b1;
   end else begin : g_prescale
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            pre <= '0;
         else if (load)                         pre <= '0;
         else if (act && pre == PRE_W'(CYC_PER_US - 1)) pre <= '0;
         else if (act)                          pre <= pre + PRE_W'(1);
      end
      assign tick = (pre == PRE_W'(CYC_PER_US - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= 1'b0;
         rem <= '0;
      end else if (load) begin
         act <= 1'b1;
         rem <= load_us;
      end else if (act && tick) begin
         if (rem == US_W'(1)) act <= 1'b0;
         else                 rem <= rem - US_W'(1);
      end
   end

   assign active = act;
   assign done   = act && tick && (rem == US_W'(1));

   assert_delay_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (act && rem == $past(load_us)));

   assert_delay_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !tick && !load) |=> $stable(rem));

endmodule

// File: rtl/regscript_flags.sv
module regscript_flags #(
   parameter int NUM_FLAGS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [4:0]           set_idx,
   input  logic                 set_drive,
   input  logic                 set_val,
   output logic [NUM_FLAGS-1:0] flag_out,
   output logic [NUM_FLAGS-1:0] flag_drive
);

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      logic q_out;
      logic q_drv;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_out <= 1'b0;
            q_drv <= 1'b0;
         end else if (set_en && set_idx == 5'(g)) begin
            q_drv <= set_drive;
            if (set_drive) q_out <= set_val;
         end
      end
      assign flag_out[g]   = q_out;
      assign flag_drive[g] = q_drv;
   end

   assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !set_en |=> ($stable(flag_out) && $stable(flag_drive)));

endmodule

// File: rtl/regscript_engine.sv
module regscript_engine
   import regscript_pkg::*;
#(
   parameter int DEPTH_WORDS = 64,
   parameter int NUM_FLAGS   = 8,
   parameter int CYC_PER_US  = 125,
   localparam int WAW = $clog2(DEPTH_WORDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 prog_we,
   input  logic [WAW-1:0]       prog_waddr,
   input  logic [31:0]          prog_wdata,
   input  logic                 start,
   output logic                 busy,
   output logic                 wr_valid,
   output logic [31:0]          wr_addr,
   output logic [31:0]          wr_data,
   input  logic [NUM_FLAGS-1:0] flag_in,
   output logic [NUM_FLAGS-1:0] flag_out,
   output logic [NUM_FLAGS-1:0] flag_drive
);

   localparam int BAW  = WAW + 2;
   localparam int PC_W = BAW + 1;
   localparam int US_W = 64;
   localparam logic [PC_W-1:0] END_PC = PC_W'(4 * DEPTH_WORDS);

   if (DEPTH_WORDS < 2 || (DEPTH_WORDS & (DEPTH_WORDS - 1)) != 0) begin : g_bad_depth
      $error("DEPTH_WORDS must be a power of two, at least 2");
   end
   if (NUM_FLAGS < 1 || NUM_FLAGS > 32) begin : g_bad_flags
      $error("NUM_FLAGS must lie in 1..32");
   end
   if (CYC_PER_US < 1) begin : g_bad_cyc
      $error("CYC_PER_US must be at least 1");
   end

   seq_state_t      state;
   arg_kind_t       arg_kind;
   logic [PC_W-1:0] pc;
   logic [31:0]     addr_q, data_q, arg_buf, arg_next;
   logic [1:0]      arg_pos, arg_last;
   logic            arg_low;
   logic [7:0]      wait_idx;
   logic            wait_val, wr_valid_q;
   logic [7:0]      cur;
   logic            at_end, is_delay, is_flag, dly_load, dly_done, dly_active, flag_sel;
   logic [US_W-1:0] dly_us;

   regscript_progmem #(.DEPTH_WORDS(DEPTH_WORDS)) u_mem (
      .clk(clk), .wr_en(prog_we), .wr_addr(prog_waddr), .wr_data(prog_wdata),
      .rd_byte_addr(pc[BAW-1:0]), .rd_byte(cur)
   );

   assign at_end   = (pc == END_PC);
   assign is_flag  = cur[7] && (cur[6:5] != 2'b11);
   assign is_delay = !cur[7] && cur != OP_ADDR_LOW && cur != OP_DATA_LOW
                     && cur != OP_WAIT_FLAG && cur != OP_END;
   assign dly_us   = US_W'(cur[1:0]) << {cur[6:2], 1'b0};
   assign dly_load = (state == ST_OPCODE) && !at_end && is_delay && (cur[1:0] != 2'b00);

   regscript_flags #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .set_en((state == ST_OPCODE) && !at_end && is_flag),
      .set_idx(cur[4:0]), .set_drive(cur[6] | cur[5]), .set_val(cur[6]),
      .flag_out(flag_out), .flag_drive(flag_drive)
   );

   regscript_delay #(.CYC_PER_US(CYC_PER_US), .US_W(US_W)) u_delay (
      .clk(clk), .rst_n(rst_n), .load(dly_load), .load_us(dly_us),
      .active(dly_active), .done(dly_done)
   );

   always_comb begin
      arg_next = arg_buf;
      arg_next[{arg_pos, 3'b000} +: 8] = cur;
   end

   always_comb begin
      flag_sel = 1'b0;
      for (int i = 0; i < NUM_FLAGS; i++) begin
         if (wait_idx == 8'(i)) flag_sel = flag_in[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         pc         <= '0;
         addr_q     <= '1;
         data_q     <= '1;
         arg_buf    <= '0;
         arg_pos    <= '0;
         arg_last   <= '0;
         arg_kind   <= AK_DATA;
         arg_low    <= 1'b0;
         wait_idx   <= '0;
         wait_val   <= 1'b0;
         wr_valid_q <= 1'b0;
      end else begin
         wr_valid_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_OPCODE;
                  pc    <= '0;
               end
            end
            ST_OPCODE: begin
               if (at_end || cur == OP_END) begin
                  state <= ST_IDLE;
               end else begin
                  pc      <= pc + PC_W'(1);
                  arg_pos <= '0;
                  arg_buf <= '0;
                  case (cur)
                     OP_DATA_FULL: begin arg_kind <= AK_DATA; arg_low <= 1'b0; arg_last <= 2'd3; state <= ST_ARGS; end
                     OP_DATA_LOW:  begin arg_kind <= AK_DATA; arg_low <= 1'b1; arg_last <= 2'd1; state <= ST_ARGS; end
                     OP_ADDR_FULL: begin arg_kind <= AK_ADDR; arg_low <= 1'b0; arg_last <= 2'd3; state <= ST_ARGS; end
                     OP_ADDR_LOW:  begin arg_kind <= AK_ADDR; arg_low <= 1'b1; arg_last <= 2'd1; state <= ST_ARGS; end
                     OP_WAIT_FLAG: begin arg_kind <= AK_WAIT; arg_low <= 1'b0; arg_last <= 2'd1; state <= ST_ARGS; end
                     default:      if (dly_load) state <= ST_DELAY;
                  endcase
               end
            end
            ST_ARGS: begin
               if (at_end) begin
                  state <= ST_IDLE;
               end else begin
                  pc      <= pc + PC_W'(1);
                  arg_buf <= arg_next;
                  arg_pos <= arg_pos + 2'd1;
                  if (arg_pos == arg_last) begin
                     state <= ST_OPCODE;
                     case (arg_kind)
                        AK_DATA: data_q <= arg_low ? {data_q[31:16], arg_next[15:0]} : arg_next;
                        AK_ADDR: begin
                           addr_q     <= arg_low ? {addr_q[31:16], arg_next[15:0]} : arg_next;
                           wr_valid_q <= 1'b1;
                        end
                        default: begin
                           wait_idx <= arg_next[7:0];
                           wait_val <= arg_next[8];
                           state    <= ST_WAIT;
                        end
                     endcase
                  end
               end
            end
            ST_WAIT:  if (flag_sel == wait_val) state <= ST_OPCODE;
            ST_DELAY: if (dly_done) state <= ST_OPCODE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign wr_valid = wr_valid_q;
   assign wr_addr  = addr_q;
   assign wr_data  = data_q;

   assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);

   assert_wr_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> busy);

   assert_wait_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && flag_sel != wait_val) |=> (state == ST_WAIT && !wr_valid));

   assert_pc_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (pc <= END_PC));

   assert_end_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OPCODE && !at_end && cur == OP_END) |=> !busy);

   assert_delay_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dly_active |-> (state == ST_DELAY));

endmodule

// File: tb/tb_regscript_engine.sv
`timescale 1ns/1ps
module tb_regscript_engine;

   localparam int DW  = 16;
   localparam int NF  = 8;
   localparam int CYC = 3;
   localparam int WAW = 4;
   localparam int NB  = DW * 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          prog_we = 1'b0;
   logic [WAW-1:0] prog_waddr = '0;
   logic [31:0]   prog_wdata = '0;
   logic          start = 1'b0;
   logic          busy, wr_valid;
   logic [31:0]   wr_addr, wr_data;
   logic [NF-1:0] flag_in = '0;
   logic [NF-1:0] flag_out, flag_drive;

   regscript_engine #(.DEPTH_WORDS(DW), .NUM_FLAGS(NF), .CYC_PER_US(CYC)) dut (
      .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_waddr(prog_waddr),
      .prog_wdata(prog_wdata), .start(start), .busy(busy), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_data(wr_data), .flag_in(flag_in),
      .flag_out(flag_out), .flag_drive(flag_drive)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   logic [7:0]  pbytes [NB];
   int          plen;
   logic [31:0] log_a [64];
   logic [31:0] log_d [64];
   int          log_n = 0;

   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         if (log_n < 64) begin
            log_a[log_n] = wr_addr;
            log_d[log_n] = wr_data;
         end
         log_n++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog (all requirements): actual %0d cycles, expected fewer", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic prog_clear();
      for (int i = 0; i < NB; i++) pbytes[i] = 8'h7F;
      plen = 0;
   endtask

   task automatic put(input logic [7:0] b);
      pbytes[plen] = b;
      plen++;
   endtask

   task automatic put16(input logic [15:0] v);
      put(v[7:0]); put(v[15:8]);
   endtask

   task automatic put32(input logic [31:0] v);
      put(v[7:0]); put(v[15:8]); put(v[23:16]); put(v[31:24]);
   endtask

   task automatic load_prog();
      for (int w = 0; w < DW; w++) begin
         @(negedge clk);
         prog_we    = 1'b1;
         prog_waddr = WAW'(w);
         prog_wdata = {pbytes[4*w+3], pbytes[4*w+2], pbytes[4*w+1], pbytes[4*w]};
      end
      @(negedge clk);
      prog_we = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run(output int bcnt);
      pulse_start();
      bcnt = 0;
      while (busy && bcnt < 5000) begin
         bcnt++;
         @(negedge clk);
      end
   endtask

   initial begin
      int bcnt, base;
      logic [31:0] d, a, d2, a2;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 wr_valid", 64'(wr_valid), 64'd0);
      chk("R1 flag_out", 64'(flag_out), 64'd0);
      chk("R1 flag_drive", 64'(flag_drive), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: bare terminator
      prog_clear();
      load_prog();
      run(bcnt);
      chk("R2 busy length for lone end byte", 64'(bcnt), 64'd1);

      // R1 R3 R4 R5: short forms applied on the all-ones reset values
      prog_clear();
      put(8'h42); put16(16'h2211);
      put(8'h40); put16(16'h4433);
      load_prog();
      base = log_n;
      run(bcnt);
      chk("R2 busy length equals byte count", 64'(bcnt), 64'd7);
      chk("R5 write count", 64'(log_n - base), 64'd1);
      chk("R1 R4 address from reset high half", 64'(log_a[base]), 64'hFFFF4433);
      chk("R1 R3 data from reset high half", 64'(log_d[base]), 64'hFFFF2211);

      // R3 R4 R5: sweep of full and short loads
      for (int i = 0; i < 8; i++) begin
         d  = 32'h9E3779B9 * 32'(i + 1);
         a  = 32'h4000_0000 + 32'h0101_0104 * 32'(i);
         d2 = 32'(16'h1111 * 16'(i) + 16'd3);
         a2 = 32'(16'h0F00 + 16'(i * 8));
         prog_clear();
         put(8'hE2); put32(d);
         put(8'hE0); put32(a);
         put(8'h42); put16(d2[15:0]);
         put(8'h40); put16(a2[15:0]);
         load_prog();
         base = log_n;
         run(bcnt);
         chk("R5 sweep write count", 64'(log_n - base), 64'd2);
         chk("R4 full address load", 64'(log_a[base]), 64'(a));
         chk("R3 full data load", 64'(log_d[base]), 64'(d));
         chk("R4 low address keeps high half", 64'(log_a[base+1]), 64'({a[31:16], a2[15:0]}));
         chk("R3 low data keeps high half", 64'(log_d[base+1]), 64'({d[31:16], d2[15:0]}));
      end

      // R4: registers persist across runs
      prog_clear();
      put(8'h40); put16(16'h0010);
      load_prog();
      base = log_n;
      run(bcnt);
      chk("R4 persistence write count", 64'(log_n - base), 64'd1);
      chk("R4 address held across runs", 64'(log_a[base]), 64'({a[31:16], 16'h0010}));
      chk("R4 data held across runs", 64'(log_d[base]), 64'({d[31:16], d2[15:0]}));

      // R6: flag drive, release and out-of-range index
      prog_clear();
      put(8'hC3); put(8'hC5); put(8'hA5); put(8'h83); put(8'hC9);
      load_prog();
      base = log_n;
      run(bcnt);
      chk("R6 flag_drive after neutral and drive-low", 64'(flag_drive), 64'h20);
      chk("R6 flag_out keeps value when released", 64'(flag_out), 64'h08);
      chk("R6 flag opcodes write nothing", 64'(log_n - base), 64'd0);

      // R7: wait for flag 2 to become 1
      prog_clear();
      put(8'h5F); put(8'h02); put(8'h01);
      put(8'hE0); put32(32'h8000_0000);
      load_prog();
      flag_in = 8'h00;
      base = log_n;
      pulse_start();
      repeat (40) @(negedge clk);
      chk("R7 stalled while flag differs: busy", 64'(busy), 64'd1);
      chk("R7 stalled while flag differs: no write", 64'(log_n - base), 64'd0);
      flag_in[2] = 1'b1;
      bcnt = 0;
      while (busy && bcnt < 100) begin bcnt++; @(negedge clk); end
      chk("R7 write after release", 64'(log_n - base), 64'd1);
      chk("R7 write address after release", 64'(log_a[base]), 64'h8000_0000);

      // R7: wait for flag 6 to become 0
      prog_clear();
      put(8'h5F); put(8'h06); put(8'h00);
      put(8'h40); put16(16'h0044);
      load_prog();
      flag_in = 8'hFF;
      base = log_n;
      pulse_start();
      repeat (25) @(negedge clk);
      chk("R7 stall on zero value: no write", 64'(log_n - base), 64'd0);
      flag_in[6] = 1'b0;
      bcnt = 0;
      while (busy && bcnt < 100) begin bcnt++; @(negedge clk); end
      chk("R7 zero-value release write", 64'(log_a[base]), 64'h8000_0044);
      flag_in = 8'h00;

      // R8: delay sweep over count 0..3 and shift 0..3
      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 4; c++) begin
            prog_clear();
            put(8'((s << 2) | c));
            load_prog();
            run(bcnt);
            chk($sformatf("R8 delay shift %0d count %0d", s, c), 64'(bcnt),
                64'(2 + c * (4 ** s) * CYC));
         end
      end

      // R9: no terminator in memory
      prog_clear();
      for (int i = 0; i < NB; i++) pbytes[i] = 8'h00;
      load_prog();
      base = log_n;
      run(bcnt);
      chk("R9 busy length to memory end", 64'(bcnt), 64'(4 * DW + 1));
      chk("R9 no writes", 64'(log_n - base), 64'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule